// File: doc/BRIEF.md
# Paced Parallel GPIO Port Engine

This block turns an 8-bit parallel data port into a general-purpose I/O port that is fed from a host byte stream. Bytes supplied on a ready/valid input stream are latched onto the port one at a time. A rate timer sets the pace, reloading from a 16-bit divisor in the way a baud-rate prescaler does. A per-pin direction mask decides which pins drive the latched value and which pins are inputs. Pin samples go back to the host on a second ready/valid stream. Two active-low strobes are brought out so that outside logic can clock on every port write and every port sample.

A mode input picks one of three behaviours. In the parked mode the port is released and both streams are idle, leaving the data lines to the normal handshake interface. In free-running mode, output bytes are applied once per timer period, and the pins are sampled once per period whether or not a write took place. In lock-step mode, the pins are sampled only together with a write, just before the new byte lands. Each returned byte therefore matches exactly one output byte, and output stalls while the return stream is full. Any change of mode empties both byte queues and clears the output latch.

Top module: `gpio_bitbang_engine`

## Requirements
- R1: After reset the port is released (pin_oe = 0), pin_out = 0, both strobes are high, out_valid is 0, and the engine is in parked mode.
- R2: mode_sel codes 0 and 3 select parked mode. In this mode pin_oe = 0, in_ready = 0, out_valid = 0 and both strobes stay high.
- R3: In the free-running (mode_sel = 1) and lock-step (mode_sel = 2) modes, pin_oe[i] equals dir_mask[i]. pin_out shows the most recently applied byte.
- R4: In free-running mode, queued bytes are applied in arrival order, one per timer period. The period is max(divisor,1) clock cycles, so consecutive pin_out updates are exactly that many cycles apart while bytes remain queued.
- R5: Each applied byte holds wr_n low for exactly one timer period. Over N applied bytes, wr_n is low for N × period cycles in total.
- R6: In free-running mode the pins are sampled once per timer period. A sample is queued only when the return queue (depth 4) has space, and each queued sample holds rd_n low for one period. With out_ready held low, exactly 4 samples are taken, and their values equal the pin state.
- R7: In lock-step mode, every returned byte is the pin state in effect just before the corresponding output byte is applied. The first byte after entering the mode reflects a latch value of 0. wr_n and rd_n move together.
- R8: In lock-step mode, output stops while the return queue is full. With out_ready low and 6 bytes sent, only 4 are applied. The rest are applied, in order, as return bytes are consumed.
- R9: A divisor of 0 gives the same period as a divisor of 1, one cycle.
- R10: A change of mode_sel flushes both queues and clears the output latch to 0. Bytes that were still queued are never applied afterwards.
- R11: While out_valid is high and out_ready is low, with the mode unchanged, out_valid stays high and out_data stays constant. in_ready is high in the active modes whenever the output queue (depth 4) has room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | 0/3 parked, 1 free-running, 2 lock-step |
| divisor | input | 16 | Timer reload value; 0 acts as 1 |
| dir_mask | input | 8 | 1 = pin drives, 0 = pin is input |
| in_valid | input | 1 | Host output byte valid |
| in_data | input | 8 | Host output byte |
| in_ready | output | 1 | Output queue accepts a byte |
| out_valid | output | 1 | Sampled byte available |
| out_data | output | 8 | Sampled pin byte |
| out_ready | input | 1 | Host takes the sampled byte |
| pin_in | input | 8 | Pin levels as seen on the port |
| pin_out | output | 8 | Latched output byte |
| pin_oe | output | 8 | Per-pin drive enable |
| wr_n | output | 1 | Active-low write strobe, one period per applied byte |
| rd_n | output | 1 | Active-low read strobe, one period per queued sample |

## Verification
The assertions check several properties on every cycle. Parked mode keeps the port released, refuses input and raises no strobe. Strobes stay paired in lock-step mode. No byte is taken from an empty output queue, and no sample is pushed into a full return queue. Timer ticks never come back to back when the divisor is above one. A waiting return byte holds steady. Other behaviours only the directed scenarios can show: the exact spacing of pin updates, the total strobe low time, the value pairing of returned bytes with earlier outputs, the release of a stall once bytes are drained, and the loss of queued bytes on a mode change.

// File: rtl/bb_pkg.sv
package bb_pkg;
  typedef enum logic [1:0] {
    BB_PARK  = 2'd0,
    BB_FREE  = 2'd1,
    BB_LOCK  = 2'd2,
    BB_PARK2 = 2'd3
  } bb_mode_e;

  function automatic logic bb_is_active(input bb_mode_e m);
    return (m == BB_FREE) || (m == BB_LOCK);
  endfunction
endpackage

// File: rtl/bb_byte_fifo.sv
module bb_byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp, wp_nxt, rp_nxt;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign rdata   = mem[rp];

  always_comb begin
    wp_nxt  = wp;
    rp_nxt  = rp;
    cnt_nxt = cnt;
    if (flush) begin
      wp_nxt  = '0;
      rp_nxt  = '0;
      cnt_nxt = '0;
    end else begin
      if (do_push) wp_nxt = adv(wp);
      if (do_pop)  rp_nxt = adv(rp);
      case ({do_push, do_pop})
        2'b10:   cnt_nxt = cnt + CW'(1);
        2'b01:   cnt_nxt = cnt - CW'(1);
        default: cnt_nxt = cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      wp  <= wp_nxt;
      rp  <= rp_nxt;
      cnt <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end
endmodule

// File: rtl/bb_rate_timer.sv
module bb_rate_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] divisor,
  output logic          tick
);
  logic [CW-1:0] cnt, cnt_nxt, period;

  assign period = (divisor == '0) ? CW'(1) : divisor;
  assign tick   = run && (cnt == '0);

  always_comb begin
    if (!run)      cnt_nxt = '0;
    else if (tick) cnt_nxt = period - CW'(1);
    else           cnt_nxt = cnt - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end
endmodule

// File: rtl/bb_port_ctrl.sv
module bb_port_ctrl
  import bb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bb_mode_e      mode,
  input  logic          flush,
  input  logic          tick,
  input  logic          tx_empty,
  input  logic [DW-1:0] tx_head,
  input  logic          rx_full,
  input  logic [DW-1:0] pin_in,
  output logic          tx_pop,
  output logic          rx_push,
  output logic [DW-1:0] rx_data,
  output logic [DW-1:0] out_latch,
  output logic          wr_n,
  output logic          rd_n
);
  logic [DW-1:0] latch_nxt;
  logic          wr_nxt, rd_nxt, lock_go;

  assign lock_go = tick && !tx_empty && !rx_full;

  always_comb begin
    tx_pop  = 1'b0;
    rx_push = 1'b0;
    if (!flush) begin
      unique case (mode)
        BB_FREE: begin
          tx_pop  = tick && !tx_empty;
          rx_push = tick && !rx_full;
        end
        BB_LOCK: begin
          tx_pop  = lock_go;
          rx_push = lock_go;
        end
        default: ;
      endcase
    end
  end

  assign rx_data = pin_in;

  always_comb begin
    latch_nxt = out_latch;
    wr_nxt    = wr_n;
    rd_nxt    = rd_n;
    if (flush) begin
      latch_nxt = '0;
      wr_nxt    = 1'b1;
      rd_nxt    = 1'b1;
    end else if (tick) begin
      if (tx_pop) latch_nxt = tx_head;
      wr_nxt = !tx_pop;
      rd_nxt = !rx_push;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_latch <= '0;
      wr_n      <= 1'b1;
      rd_n      <= 1'b1;
    end else begin
      out_latch <= latch_nxt;
      wr_n      <= wr_nxt;
      rd_n      <= rd_nxt;
    end
  end
endmodule

// File: rtl/gpio_bitbang_engine.sv
module gpio_bitbang_engine
  import bb_pkg::*;
#(
  parameter int DW       = 8,
  parameter int DIV_W    = 16,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic [DIV_W-1:0] divisor,
  input  logic [DW-1:0]    dir_mask,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [DW-1:0]    out_data,
  input  logic             out_ready,
  input  logic [DW-1:0]    pin_in,
  output logic [DW-1:0]    pin_out,
  output logic [DW-1:0]    pin_oe,
  output logic             wr_n,
  output logic             rd_n
);
  bb_mode_e      mode, mode_q;
  logic          flush, active, tick;
  logic          tx_empty, tx_full, tx_pop, tx_push;
  logic          rx_empty, rx_full, rx_push, rx_pop;
  logic [DW-1:0] tx_head, rx_wdata;

  assign mode   = bb_mode_e'(mode_sel);
  assign active = bb_is_active(mode);
  assign flush  = (mode != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= BB_PARK;
    else        mode_q <= mode;
  end

  assign in_ready  = active && !flush && !tx_full;
  assign tx_push   = in_valid && in_ready;
  assign out_valid = !rx_empty && !flush;
  assign rx_pop    = out_valid && out_ready;

  bb_rate_timer #(.CW(DIV_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (active && !flush),
    .divisor (divisor),
    .tick    (tick)
  );

  bb_byte_fifo #(.W(DW), .DEPTH(TX_DEPTH)) u_txq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (tx_push),
    .wdata (in_data),
    .pop   (tx_pop),
    .rdata (tx_head),
    .empty (tx_empty),
    .full  (tx_full)
  );

  bb_byte_fifo #(.W(DW), .DEPTH(RX_DEPTH)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (rx_push),
    .wdata (rx_wdata),
    .pop   (rx_pop),
    .rdata (out_data),
    .empty (rx_empty),
    .full  (rx_full)
  );

  bb_port_ctrl #(.DW(DW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .flush     (flush),
    .tick      (tick),
    .tx_empty  (tx_empty),
    .tx_head   (tx_head),
    .rx_full   (rx_full),
    .pin_in    (pin_in),
    .tx_pop    (tx_pop),
    .rx_push   (rx_push),
    .rx_data   (rx_wdata),
    .out_latch (pin_out),
    .wr_n      (wr_n),
    .rd_n      (rd_n)
  );

  for (genvar i = 0; i < DW; i++) begin : g_drive
    assign pin_oe[i] = active && dir_mask[i];
  end
endmodule

// File: rtl/bb_engine_checks.sv
module bb_engine_checks #(
  parameter int DW    = 8,
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_sel,
  input logic [DIV_W-1:0] divisor,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [DW-1:0]    out_data,
  input logic [DW-1:0]    pin_oe,
  input logic             wr_n,
  input logic             rd_n,
  input logic             tick,
  input logic             tx_pop,
  input logic             tx_empty,
  input logic             rx_push,
  input logic             rx_full
);
  logic parked;
  assign parked = (mode_sel == 2'd0) || (mode_sel == 2'd3);

  a_r2_parked_idle: assert property (@(posedge clk) disable iff (!rst_n)
    parked |-> (!in_ready && !out_valid && (pin_oe == '0)));

  a_r2_parked_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(parked) && parked) |-> (wr_n && rd_n));

  a_r7_lock_paired: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_sel) == 2'd2) |-> (wr_n == rd_n));

  a_r4_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty);

  a_r6_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full);

  a_r9_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tick) && ($past(divisor) > DIV_W'(1)) && $stable(divisor) && $stable(mode_sel))
      |-> !tick);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(out_valid && !out_ready) && $stable(mode_sel)) |-> (out_valid && $stable(out_data)));
endmodule

bind gpio_bitbang_engine bb_engine_checks #(.DW(DW), .DIV_W(DIV_W)) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_sel  (mode_sel),
  .divisor   (divisor),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .pin_oe    (pin_oe),
  .wr_n      (wr_n),
  .rd_n      (rd_n),
  .tick      (tick),
  .tx_pop    (tx_pop),
  .tx_empty  (tx_empty),
  .rx_push   (rx_push),
  .rx_full   (rx_full)
);

// File: tb/gpio_bitbang_engine_test.sv
`timescale 1ns/1ps
module gpio_bitbang_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_sel = 2'd0;
  logic [15:0] divisor = 16'd1;
  logic [7:0]  dir_mask = 8'hFF;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready, out_valid;
  logic [7:0]  out_data;
  logic        out_ready = 1'b0;
  logic [7:0]  pin_in, pin_out, pin_oe, ext_drive;
  logic        wr_n, rd_n;

  int total = 0, bad = 0;
  int cyc = 0, wr_tot = 0, rd_tot = 0, chg_tot = 0;
  int chg_cyc [64];
  logic [7:0] chg_val [64];
  logic [7:0] last_out = 8'h00;
  int wr_base, rd_base, chg_base;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign pin_in = (pin_out & pin_oe) | (ext_drive & ~pin_oe);

  gpio_bitbang_engine uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .divisor(divisor),
    .dir_mask(dir_mask), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .wr_n(wr_n), .rd_n(rd_n)
  );

  always @(negedge clk) begin
    cyc++;
    if (!wr_n) wr_tot++;
    if (!rd_n) rd_tot++;
    if (pin_out !== last_out) begin
      chg_cyc[chg_tot % 64] = cyc;
      chg_val[chg_tot % 64] = pin_out;
      chg_tot++;
    end
    last_out = pin_out;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode_sel = m;
    #1;
    wr_base = wr_tot; rd_base = rd_tot; chg_base = chg_tot;
    repeat (2) @(negedge clk);
  endtask

  task automatic push_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic pop_byte(output logic [7:0] b);
    int lim = 0;
    @(negedge clk);
    out_ready = 1'b1;
    while (!out_valid && lim < 400) begin @(negedge clk); lim++; end
    b = out_data;
    @(posedge clk);
    #1 out_ready = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(pin_oe == 8'h00, "R1 oe", pin_oe, 0);
    chk(pin_out == 8'h00, "R1 pin_out", pin_out, 0);
    chk(wr_n && rd_n, "R1 strobes", {wr_n, rd_n}, 3);
    chk(!out_valid, "R1 out_valid", out_valid, 0);
    chk(!in_ready, "R2 parked in_ready", in_ready, 0);
  endtask

  task automatic t_free_pacing;
    divisor = 16'd5; dir_mask = 8'hFF; out_ready = 1'b0;
    set_mode(2'd1);
    chk(pin_oe == 8'hFF, "R3 oe full mask", pin_oe, 8'hFF);
    push_byte(8'hA5); push_byte(8'h3C); push_byte(8'hF0);
    wait_cyc(30);
    chk(chg_tot - chg_base == 3, "R4 update count", chg_tot - chg_base, 3);
    chk(chg_val[chg_base % 64] == 8'hA5, "R4 first byte", chg_val[chg_base % 64], 8'hA5);
    chk(chg_val[(chg_base + 1) % 64] == 8'h3C, "R4 second byte", chg_val[(chg_base + 1) % 64], 8'h3C);
    chk(chg_val[(chg_base + 2) % 64] == 8'hF0, "R4 third byte", chg_val[(chg_base + 2) % 64], 8'hF0);
    chk(chg_cyc[(chg_base + 1) % 64] - chg_cyc[chg_base % 64] == 5, "R4 spacing 1",
        chg_cyc[(chg_base + 1) % 64] - chg_cyc[chg_base % 64], 5);
    chk(chg_cyc[(chg_base + 2) % 64] - chg_cyc[(chg_base + 1) % 64] == 5, "R4 spacing 2",
        chg_cyc[(chg_base + 2) % 64] - chg_cyc[(chg_base + 1) % 64], 5);
    chk(wr_tot - wr_base == 15, "R5 wr low cycles", wr_tot - wr_base, 15);
    set_mode(2'd0);
  endtask

  task automatic t_free_sampling;
    logic [7:0] b, d0;
    divisor = 16'd3; dir_mask = 8'h00; ext_drive = 8'h5A; out_ready = 1'b0;
    set_mode(2'd1);
    chk(pin_oe == 8'h00, "R3 oe empty mask", pin_oe, 0);
    wait_cyc(40);
    chk(rd_tot - rd_base == 12, "R6 rd low cycles with full queue", rd_tot - rd_base, 12);
    chk(out_valid, "R6 sample available", out_valid, 1);
    d0 = out_data;
    wait_cyc(5);
    chk(out_valid && out_data == d0, "R11 held byte", out_data, d0);
    for (int i = 0; i < 4; i++) begin
      pop_byte(b);
      chk(b == 8'h5A, "R6 sample value", b, 8'h5A);
    end
    dir_mask = 8'h0F;
    @(negedge clk);
    chk(pin_oe == 8'h0F, "R3 partial mask", pin_oe, 8'h0F);
    set_mode(2'd0);
  endtask

  task automatic t_lock_pairing;
    logic [7:0] b;
    divisor = 16'd2; dir_mask = 8'h0F; ext_drive = 8'hA0; out_ready = 1'b0;
    set_mode(2'd2);
    push_byte(8'h01); push_byte(8'h02); push_byte(8'h03);
    wait_cyc(20);
    chk(pin_out == 8'h03, "R7 last applied", pin_out, 8'h03);
    chk(wr_tot - wr_base == 6, "R5 lock wr cycles", wr_tot - wr_base, 6);
    chk(rd_tot - rd_base == 6, "R7 lock rd cycles", rd_tot - rd_base, 6);
    for (int i = 0; i < 3; i++) begin
      pop_byte(b);
      chk(b == (8'hA0 | 8'(i)), "R7 paired sample", b, 8'hA0 | 8'(i));
    end
    set_mode(2'd0);
  endtask

  task automatic t_lock_stall;
    logic [7:0] b;
    divisor = 16'd1; dir_mask = 8'hFF; out_ready = 1'b0;
    set_mode(2'd2);
    for (int i = 0; i < 6; i++) push_byte(8'h10 + 8'(i));
    wait_cyc(20);
    chk(pin_out == 8'h13, "R8 stalled at fourth byte", pin_out, 8'h13);
    chk(wr_tot - wr_base == 4, "R8 writes while stalled", wr_tot - wr_base, 4);
    pop_byte(b);
    chk(b == 8'h00, "R8 first return", b, 0);
    for (int i = 0; i < 5; i++) begin
      pop_byte(b);
      chk(b == 8'h10 + 8'(i), "R8 drained return", b, 8'h10 + 8'(i));
    end
    wait_cyc(5);
    chk(pin_out == 8'h15, "R8 resumed to last byte", pin_out, 8'h15);
    set_mode(2'd0);
  endtask

  task automatic t_zero_divisor;
    divisor = 16'd0; dir_mask = 8'hFF; out_ready = 1'b1;
    set_mode(2'd1);
    push_byte(8'h81); push_byte(8'h42); push_byte(8'h24);
    wait_cyc(10);
    chk(chg_tot - chg_base == 3, "R9 update count", chg_tot - chg_base, 3);
    chk(chg_cyc[(chg_base + 1) % 64] - chg_cyc[chg_base % 64] == 1, "R9 spacing 1",
        chg_cyc[(chg_base + 1) % 64] - chg_cyc[chg_base % 64], 1);
    chk(chg_cyc[(chg_base + 2) % 64] - chg_cyc[(chg_base + 1) % 64] == 1, "R9 spacing 2",
        chg_cyc[(chg_base + 2) % 64] - chg_cyc[(chg_base + 1) % 64], 1);
    out_ready = 1'b0;
    set_mode(2'd0);
  endtask

  task automatic t_flush;
    int lim = 0;
    divisor = 16'd50; dir_mask = 8'hFF; out_ready = 1'b0;
    set_mode(2'd1);
    push_byte(8'h11); push_byte(8'h22); push_byte(8'h33);
    while (pin_out != 8'h11 && lim < 120) begin @(negedge clk); lim++; end
    chk(pin_out == 8'h11, "R10 first byte before switch", pin_out, 8'h11);
    set_mode(2'd2);
    chk(!out_valid, "R10 return queue flushed", out_valid, 0);
    chk(pin_out == 8'h00, "R10 latch cleared", pin_out, 0);
    wait_cyc(120);
    chk(pin_out == 8'h00 && wr_tot == wr_base, "R10 stale bytes dropped", pin_out, 0);
    set_mode(2'd1);
    wait_cyc(10);
    chk(out_valid, "R6 samples before park", out_valid, 1);
    set_mode(3'd3);
    chk(!out_valid && !in_ready, "R2 code 3 idle", {out_valid, in_ready}, 0);
    chk(pin_oe == 8'h00 && wr_n && rd_n, "R2 code 3 released", pin_oe, 0);
    set_mode(2'd0);
  endtask

  initial begin
    ext_drive = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_free_pacing();
    t_free_sampling();
    t_lock_pairing();
    t_lock_stall();
    t_zero_divisor();
    t_flush();
    wait_cyc(4);
    chk(in_ready == 1'b0, "R2 parked after run", in_ready, 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule